// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Compare Channel

This block is a triangle-wave counter that drives one compare output. Once started, the counter climbs one step per prescaled tick from zero to a programmed peak. It then reverses and falls back to zero, and repeats this for as long as it runs. The single compare channel raises its output when the counter meets the compare value on the way up and drops it when the counter meets the compare value on the way down. The result is a pulse centred on the peak of the triangle.

Software reaches the block through a small write/read register port. Both the compare value and the peak value can be double-buffered, so that a new value takes effect only at the zero point of the triangle. A zero-point flag can raise an interrupt, and a peak flag records each turnaround at the top. The counter also exports its direction and one-cycle zero and peak strobes to neighbouring blocks.

Register map (address: contents):

- Address 0, control:
  - bit 0: run
  - bit 1: soft clear (write-only pulse)
  - bits 3:2: prescale select
  - bit 4: peak buffering
  - bit 5: zero interrupt enable
  - bit 6: zero flag
  - bit 7: peak flag
- Address 1: peak value.
- Address 2: compare value.
- Address 3, channel:
  - bit 0: enable
  - bit 1: idle level
  - bit 2: compare buffering
- Address 4: counter value.

Top module: `ctr_pwm_timer`

## Requirements
- R1: While running, the counter steps 0, 1, … up to the active peak, then down to 0, and repeats. `count_up` is 1 while rising. An active peak of 0 holds the counter at 0. If the count is already at or above the active peak while rising, it turns down without setting the peak flag.
- R2: The counter advances once every 2^s clock cycles, where s is control bits 3:2.
- R3: With the channel enabled, a step that lands on the active compare value drives `pwm_out` high if the step was upward and low if it was downward. Otherwise `pwm_out` holds.
- R4: When channel bit 2 is 1, a compare write goes only to the buffer. The buffer is copied to the active compare value at the zero event or on a soft clear. When channel bit 2 is 0, the write takes effect at once.
- R5: Control bit 4 selects the same buffered or immediate behaviour for the peak value.
- R6: A downward step onto 0 sets the zero flag (control bit 6). Starting the counter from 0 does not set it. `irq_zero` is 1 exactly when the zero flag and control bit 5 are both 1.
- R7: The zero flag clears when 0 is written to control bit 6; writing 1 leaves it unchanged. The peak flag (control bit 7) is set by an upward step onto the peak and clears the same way. If a flag is set and cleared in the same cycle, the set wins.
- R8: Writing 1 to control bit 1 sets the count to 0 and the direction to up. It also reloads both buffered values and sets no flag.
- R9: Control bit 0 starts (1) and stops (0) counting. A write to address 4 loads the count, with direction up, only while stopped; while running the write has no effect.
- R10: With channel bit 0 at 0, `pwm_out` follows channel bit 1 one cycle later. On re-enable, the output keeps that level until the next match.
- R11: `zero_stb` and `peak_stb` are one-cycle pulses, high in the cycle in which `count` first shows 0 after falling or first shows the peak after rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| pwm_out | output | 1 | Compare channel output |
| irq_zero | output | 1 | Zero-point interrupt request |
| count | output | 16 | Current counter value |
| count_up | output | 1 | Counter direction, 1 while rising |
| zero_stb | output | 1 | Pulse when the count reaches zero |
| peak_stb | output | 1 | Pulse when the count reaches the peak |

## Verification
Two pairs of events can land on the same clock edge.

- **Zero event and flag clear.** The bench watches its own model, waits until the counter stands at 1 while falling, and issues a control write that clears the zero flag on the very edge where the count reaches 0. The flag must then read back as set, per the set-wins rule.
- **Zero event and buffered compare write.** A buffered compare write is placed on the zero-event edge. The active compare value must take the old buffer contents while the buffer takes the new word.

The per-cycle comparison of `pwm_out` against the model decides both cases.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
    localparam int ADDR_W = 3;
    localparam int PSEL_W = 2;
    localparam int PRE_W  = (1 << PSEL_W) - 1;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PEAK  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CHAN  = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;

    // control word bit positions
    localparam int C_RUN  = 0;
    localparam int C_SCLR = 1;
    localparam int C_PSL  = 2;
    localparam int C_PBUF = 4;
    localparam int C_ZIE  = 5;
    localparam int C_ZFL  = 6;
    localparam int C_PFL  = 7;

    // channel word bit positions
    localparam int H_EN   = 0;
    localparam int H_IDLE = 1;
    localparam int H_CBUF = 2;

    typedef struct packed {
        logic              pflag;
        logic              zflag;
        logic              zie;
        logic              pbuf;
        logic [PSEL_W-1:0] psel;
        logic              run;
    } ctrl_t;

    typedef struct packed {
        logic cbuf;
        logic idle;
        logic en;
    } chan_t;

    function automatic logic [PRE_W-1:0] pre_mask(input logic [PSEL_W-1:0] s);
        return PRE_W'((PRE_W+1)'(1) << s) - PRE_W'(1);
    endfunction
endpackage

// File: rtl/ptm_prescaler.sv
module ptm_prescaler
    import ptm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              clr,
    input  logic [PSEL_W-1:0] sel,
    output logic              tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = pre_mask(sel);
        tick = run && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || clr) pre_q <= '0;
        else                    pre_q <= pre_q + PRE_W'(1);
    end
endmodule

// File: rtl/ptm_counter.sv
module ptm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         sclr,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] peak,
    output logic [W-1:0] cnt,
    output logic         up,
    output logic [W-1:0] cnt_nxt,
    output logic         step_up,
    output logic         adv,
    output logic         zero_evt,
    output logic         peak_evt,
    output logic         zero_stb,
    output logic         peak_stb
);
    logic up_nxt;

    always_comb begin
        adv     = tick && !sclr;
        cnt_nxt = cnt;
        up_nxt  = up;
        if (adv) begin
            if (up) begin
                if (cnt >= peak) begin
                    if (cnt != '0) begin
                        cnt_nxt = cnt - W'(1);
                        up_nxt  = 1'b0;
                    end
                end else begin
                    cnt_nxt = cnt + W'(1);
                end
            end else if (cnt == '0) begin
                up_nxt  = 1'b1;
                cnt_nxt = (peak == '0) ? '0 : W'(1);
            end else begin
                cnt_nxt = cnt - W'(1);
            end
        end
        step_up  = adv && (cnt_nxt > cnt);
        zero_evt = adv && !up && (cnt == W'(1));
        peak_evt = adv && up && (cnt < peak) && (cnt + W'(1) == peak);
    end

    always_ff @(posedge clk) begin
        if (rst || sclr) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (ld_en) begin
            cnt <= ld_val;
            up  <= 1'b1;
        end else begin
            cnt <= cnt_nxt;
            up  <= up_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_stb <= 1'b0;
            peak_stb <= 1'b0;
        end else begin
            zero_stb <= zero_evt;
            peak_stb <= peak_evt;
        end
    end
endmodule

// File: rtl/ptm_compare.sv
module ptm_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         idle,
    input  logic         adv,
    input  logic         step_up,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] cmp,
    output logic         out
);
    always_ff @(posedge clk) begin
        if (rst)                        out <= 1'b0;
        else if (!en)                   out <= idle;
        else if (adv && cnt_nxt == cmp) out <= step_up;
    end
endmodule

// File: rtl/ctr_pwm_timer.sv
module ctr_pwm_timer
    import ptm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic              pwm_out,
    output logic              irq_zero,
    output logic [W-1:0]      count,
    output logic              count_up,
    output logic              zero_stb,
    output logic              peak_stb
);
    ctrl_t        ctrl_q;
    chan_t        chan_q;
    logic [W-1:0] peak_buf, peak_act, cmp_buf, cmp_act;
    logic         run_q, ch_en, idle_q;

    logic w_ctrl, w_peak, w_cmp, w_chan, w_cnt, sclr, load;
    logic tick, adv, step_up, zero_evt, peak_evt;
    logic [W-1:0] cnt_nxt;

    assign run_q  = ctrl_q.run;
    assign ch_en  = chan_q.en;
    assign idle_q = chan_q.idle;

    always_comb begin
        w_ctrl = wr_en && (wr_addr == A_CTRL);
        w_peak = wr_en && (wr_addr == A_PEAK);
        w_cmp  = wr_en && (wr_addr == A_CMP);
        w_chan = wr_en && (wr_addr == A_CHAN);
        w_cnt  = wr_en && (wr_addr == A_COUNT);
        sclr   = w_ctrl && wr_data[C_SCLR];
        load   = zero_evt || sclr;
    end

    ptm_prescaler u_pre (
        .clk (clk),
        .rst (rst),
        .run (ctrl_q.run),
        .clr (sclr),
        .sel (ctrl_q.psel),
        .tick(tick)
    );

    ptm_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .sclr    (sclr),
        .ld_en   (w_cnt && !ctrl_q.run),
        .ld_val  (wr_data),
        .peak    (peak_act),
        .cnt     (count),
        .up      (count_up),
        .cnt_nxt (cnt_nxt),
        .step_up (step_up),
        .adv     (adv),
        .zero_evt(zero_evt),
        .peak_evt(peak_evt),
        .zero_stb(zero_stb),
        .peak_stb(peak_stb)
    );

    ptm_compare #(.W(W)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .en     (chan_q.en),
        .idle   (chan_q.idle),
        .adv    (adv),
        .step_up(step_up),
        .cnt_nxt(cnt_nxt),
        .cmp    (cmp_act),
        .out    (pwm_out)
    );

    // control register with write-0-to-clear flags; event set wins
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (w_ctrl) begin
                ctrl_q.run  <= wr_data[C_RUN];
                ctrl_q.psel <= wr_data[C_PSL +: PSEL_W];
                ctrl_q.pbuf <= wr_data[C_PBUF];
                ctrl_q.zie  <= wr_data[C_ZIE];
            end
            if (zero_evt)                    ctrl_q.zflag <= 1'b1;
            else if (w_ctrl && !wr_data[C_ZFL]) ctrl_q.zflag <= 1'b0;
            if (peak_evt)                    ctrl_q.pflag <= 1'b1;
            else if (w_ctrl && !wr_data[C_PFL]) ctrl_q.pflag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         chan_q <= '0;
        else if (w_chan) chan_q <= chan_t'(wr_data[2:0]);
    end

    // double-buffered peak and compare values
    always_ff @(posedge clk) begin
        if (rst) begin
            peak_buf <= '0;
            peak_act <= '0;
            cmp_buf  <= '0;
            cmp_act  <= '0;
        end else begin
            if (w_peak) peak_buf <= wr_data;
            if (w_peak && !ctrl_q.pbuf) peak_act <= wr_data;
            else if (load)              peak_act <= peak_buf;
            if (w_cmp) cmp_buf <= wr_data;
            if (w_cmp && !chan_q.cbuf)  cmp_act <= wr_data;
            else if (load)              cmp_act <= cmp_buf;
        end
    end

    assign irq_zero = ctrl_q.zflag && ctrl_q.zie;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data[7:0] = {ctrl_q.pflag, ctrl_q.zflag, ctrl_q.zie,
                                     ctrl_q.pbuf, ctrl_q.psel, 1'b0, ctrl_q.run};
            A_PEAK:  rd_data = peak_buf;
            A_CMP:   rd_data = cmp_buf;
            A_CHAN:  rd_data[2:0] = chan_q;
            A_COUNT: rd_data = count;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ptm_checker.sv
module ptm_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic         run_q,
    input logic         ch_en,
    input logic         idle_q,
    input logic         zflag,
    input logic         pwm_out,
    input logic [W-1:0] count,
    input logic         zero_stb,
    input logic         peak_stb
);
    p_single_step_r1: assert property (@(posedge clk) disable iff (rst)
        $past(!wr_en) |-> (count == $past(count) || count == $past(count) + W'(1)
                           || count == $past(count) - W'(1)));

    p_stopped_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(!run_q) && $past(!wr_en)) |-> $stable(count));

    p_rise_up_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwm_out) && $past(ch_en)) |-> (count > $past(count)));

    p_fall_down_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(pwm_out) && $past(ch_en)) |-> (count < $past(count)));

    p_idle_level_r10: assert property (@(posedge clk) disable iff (rst)
        $past(!ch_en) |-> (pwm_out == $past(idle_q)));

    p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
        zero_stb |-> zflag);

    p_zero_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        zero_stb |-> (count == '0));

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(zero_stb && peak_stb));
endmodule

bind ctr_pwm_timer ptm_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .run_q   (run_q),
    .ch_en   (ch_en),
    .idle_q  (idle_q),
    .zflag   (ctrl_q.zflag),
    .pwm_out (pwm_out),
    .count   (count),
    .zero_stb(zero_stb),
    .peak_stb(peak_stb)
);

// File: tb/tb_ctr_pwm_timer.sv
module tb_ctr_pwm_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        pwm_out, irq_zero, count_up, zero_stb, peak_stb;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ctr_pwm_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out), .irq_zero(irq_zero),
        .count(count), .count_up(count_up), .zero_stb(zero_stb), .peak_stb(peak_stb)
    );

    // reference model state
    int m_cnt, m_up, m_pre, m_run, m_psel, m_pbuf, m_zie, m_zf, m_pf;
    int m_pkb, m_pka, m_cmb, m_cma, m_en, m_idle, m_cbuf, m_out, m_zs, m_ps;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin : model
        int d, mask, ncnt, nup, tick, adv, zev, pev, sclr, wc;
        if (rst) begin
            m_cnt = 0; m_up = 1; m_pre = 0; m_run = 0; m_psel = 0; m_pbuf = 0;
            m_zie = 0; m_zf = 0; m_pf = 0; m_pkb = 0; m_pka = 0; m_cmb = 0;
            m_cma = 0; m_en = 0; m_idle = 0; m_cbuf = 0; m_out = 0; m_zs = 0; m_ps = 0;
        end else begin
            d    = int'(wr_data);
            wc   = (wr_en && wr_addr == 3'd0) ? 1 : 0;
            sclr = (wc && d[1]) ? 1 : 0;
            mask = (1 << m_psel) - 1;
            tick = (m_run && ((m_pre & mask) == mask)) ? 1 : 0;
            adv  = (tick && !sclr) ? 1 : 0;
            ncnt = m_cnt; nup = m_up;
            if (adv) begin
                if (m_up) begin
                    if (m_cnt < m_pka) ncnt = m_cnt + 1;
                    else if (m_cnt > 0) begin ncnt = m_cnt - 1; nup = 0; end
                end else if (m_cnt == 0) begin
                    nup = 1; ncnt = (m_pka > 0) ? 1 : 0;
                end else ncnt = m_cnt - 1;
            end
            zev = (adv && !m_up && m_cnt == 1) ? 1 : 0;
            pev = (adv && m_up && m_cnt + 1 == m_pka) ? 1 : 0;
            // output
            if (!m_en) m_out = m_idle;
            else if (adv && ncnt == m_cma) m_out = (ncnt > m_cnt) ? 1 : 0;
            // active values use old buffers
            if (wr_en && wr_addr == 3'd1 && !m_pbuf) m_pka = d;
            else if (zev || sclr) m_pka = m_pkb;
            if (wr_en && wr_addr == 3'd2 && !m_cbuf) m_cma = d;
            else if (zev || sclr) m_cma = m_cmb;
            if (wr_en && wr_addr == 3'd1) m_pkb = d;
            if (wr_en && wr_addr == 3'd2) m_cmb = d;
            // flags
            if (zev) m_zf = 1; else if (wc && !d[6]) m_zf = 0;
            if (pev) m_pf = 1; else if (wc && !d[7]) m_pf = 0;
            // count
            if (sclr) begin m_cnt = 0; m_up = 1; end
            else if (wr_en && wr_addr == 3'd4 && !m_run) begin m_cnt = d; m_up = 1; end
            else begin m_cnt = ncnt; m_up = nup; end
            m_pre = (!m_run || sclr) ? 0 : (m_pre + 1) % 8;
            m_zs = zev; m_ps = pev;
            if (wc) begin
                m_run = d[0]; m_psel = (d >> 2) & 3; m_pbuf = d[4]; m_zie = d[5];
            end
            if (wr_en && wr_addr == 3'd3) begin
                m_en = d[0]; m_idle = d[1]; m_cbuf = d[2];
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 count", int'(count), m_cnt);
            chk("R1 count_up", int'(count_up), m_up);
            chk("R3,R4,R10 pwm_out", int'(pwm_out), m_out);
            chk("R6 irq_zero", int'(irq_zero), (m_zf && m_zie) ? 1 : 0);
            chk("R11 zero_stb", int'(zero_stb), m_zs);
            chk("R11 peak_stb", int'(peak_stb), m_ps);
        end
    end

    function automatic logic [15:0] cw(int run, int sclr, int psel, int pbuf,
                                       int zie, int zf, int pf);
        return 16'(run | (sclr << 1) | (psel << 2) | (pbuf << 4) | (zie << 5)
                   | (zf << 6) | (pf << 7));
    endfunction

    // called at a falling edge, returns at the next one
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
        rd_addr = a;
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int c0, gap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state
        chk("R9 reset count", int'(count), 0);
        chk("R10 reset pwm", int'(pwm_out), 0);
        rd_chk("R9 reset ctrl", 3'd0, 0);

        // setup: peak 10 immediate, compare 4 buffered, channel on, idle low
        wr(3'd1, 16'd10);
        wr(3'd3, 16'b101);
        wr(3'd2, 16'd4);
        rd_chk("R4 compare buffer readback", 3'd2, 4);
        wr(3'd0, cw(0, 1, 0, 0, 1, 1, 1));   // soft clear loads compare
        wr(3'd0, cw(1, 0, 0, 0, 1, 1, 1));   // run
        idle_cycles(3);
        rd_chk("R6 no zero flag at start", 3'd0, int'(cw(1, 0, 0, 0, 1, 0, 0)));
        idle_cycles(10);
        rd_chk("R7 peak flag set", 3'd0, int'(cw(1, 0, 0, 0, 1, 0, 1)));
        // mid-cycle buffered compare write
        wr(3'd2, 16'd7);
        idle_cycles(30);
        chk("R6 irq raised after zero", int'(irq_zero), 1);

        // write 1 keeps, write 0 clears
        wr(3'd0, cw(1, 0, 0, 0, 1, 1, 1));
        chk("R7 write one keeps flag", int'(irq_zero), 1);
        wr(3'd0, cw(1, 0, 0, 0, 1, 0, 0));
        rd_chk("R7 write zero clears", 3'd0, int'(cw(1, 0, 0, 0, 1, m_zf, 0)));

        // collision: clear write on the zero-event edge
        while (!(m_cnt == 1 && m_up == 0)) @(negedge clk);
        wr(3'd0, cw(1, 0, 0, 0, 1, 0, 1));
        rd_chk("R7 set wins over clear", 3'd0, int'(cw(1, 0, 0, 0, 1, 1, m_pf)));
        // collision: buffered compare write on the reload edge
        while (!(m_cnt == 1 && m_up == 0)) @(negedge clk);
        wr(3'd2, 16'd3);
        idle_cycles(25);

        // prescaler divide by 4
        wr(3'd0, cw(1, 0, 2, 0, 1, 1, 1));
        c0 = int'(count);
        while (int'(count) == c0) @(negedge clk);
        c0 = int'(count); gap = 0;
        while (int'(count) == c0) begin @(negedge clk); gap++; end
        chk("R2 divide by four spacing", gap, 4);
        idle_cycles(60);

        // peak buffered
        wr(3'd0, cw(1, 0, 0, 1, 1, 1, 1));
        wr(3'd1, 16'd6);
        rd_chk("R5 peak buffer readback", 3'd1, 6);
        idle_cycles(40);
        chk("R5 peak applied after zero", m_pka, 6);

        // count write while running has no effect
        wr(3'd4, 16'd3);
        idle_cycles(5);

        // stop, hold, load count
        wr(3'd0, cw(0, 0, 0, 1, 1, 1, 1));
        c0 = int'(count);
        idle_cycles(5);
        chk("R9 stopped count holds", int'(count), c0);
        wr(3'd4, 16'd2);
        chk("R9 count load when stopped", int'(count), 2);
        wr(3'd0, cw(1, 0, 0, 1, 1, 1, 1));
        idle_cycles(20);

        // channel disabled with idle high, then re-enable
        wr(3'd3, 16'b110);
        idle_cycles(2);
        chk("R10 idle level", int'(pwm_out), 1);
        idle_cycles(20);
        wr(3'd3, 16'b111);
        idle_cycles(30);

        // soft clear while running
        wr(3'd0, cw(1, 1, 0, 1, 1, 1, 1));
        chk("R8 soft clear count", int'(count), 0);
        idle_cycles(10);

        // unbuffered peak of zero holds the counter
        wr(3'd0, cw(1, 0, 0, 0, 1, 1, 1));
        wr(3'd1, 16'd0);
        idle_cycles(30);
        chk("R1 zero peak holds", int'(count), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule